// File: doc/BRIEF.md
# Drop-and-Retry Output-Queued Packet Switch

This block is one switching node of a wormhole on-chip network. Each of its inputs receives flits of four kinds: idle, head, body and tail. A head flit carries a source route, and the switch reads its own output choice from the low bits of that route. Heads that want the same output go to a per-output allocator. The allocator picks a winner by fixed priority or by round robin, as a parameter selects. The winning input then owns that output until its tail flit has been accepted.

Upstream senders never see backpressure. Every flit the switch takes gets an ACK one cycle after it is presented. A flit the switch cannot take gets a NACK instead and is discarded. A flit is refused when its output is owned by another packet, when it loses arbitration, or when its output queue is full. After a refusal, the input discards the rest of that packet until a new head arrives, so the sender must resend from the head. Accepted flits go into a FIFO at their output. Head flits have their route shifted so that the next node finds its own selection in the low bits. The outputs drain under the downstream ready signal, and an accepted flit reaches an idle output two cycles after it was presented.

Top module: `gbn_switch`

## Requirements
- R1: A flit accepted on the cycle it is presented (edge E0) appears on its output after the following edge (E1), provided that output queue was empty and its register was free. The flit is not on the output before E1.
- R2: A valid non-idle flit gets exactly one of ACK or NACK, registered, one cycle after it is presented. An input that presents nothing, or presents the idle kind, gets neither. Kind encoding: 0 idle, 1 head, 2 body, 3 tail.
- R3: A head flit leaves with its route shifted right by log2(NOUT) bits. Those low log2(NOUT) bits had selected the output. Body and tail flits leave with their route field unchanged.
- R4: With fixed priority, the lowest-numbered requesting input wins when several heads want the same free output.
- R5: With round robin, each output keeps a pointer that starts at input 0. The search for a winner starts at the pointer. After a head is granted, the pointer moves to the input just after the winner.
- R6: A head that asks for an output owned by another input's packet is NACKed. Ownership ends when the owner's tail is accepted, and the output is then free to a new head.
- R7: When an output queue already holds QDEPTH flits, any flit bound for that output is NACKed and the queue is not written.
- R8: After a refusal, the input NACKs every later body and tail flit, even when the output is free, and the path that input held is released.
- R9: A head flit clears the input's refusal state and is then judged like any other head.
- R10: Each output delivers its flits in acceptance order. While its ready input is low, the output holds its valid flit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NIN | Flit present, one bit per input |
| in_kind | input | 2*NIN | Flit kind per input (0 idle, 1 head, 2 body, 3 tail) |
| in_route | input | RW*NIN | Source route per input |
| in_data | input | DW*NIN | Payload per input |
| in_ack | output | NIN | Flit accepted, one cycle after presentation |
| in_nack | output | NIN | Flit refused, one cycle after presentation |
| out_ready | input | NOUT | Downstream takes the current output flit |
| out_valid | output | NOUT | Output flit present |
| out_kind | output | 2*NOUT | Kind of each output flit |
| out_route | output | RW*NOUT | Route of each output flit, shifted for heads |
| out_data | output | DW*NOUT | Payload of each output flit |

## Verification
A wrong ownership record shows at the ports as a NACK where an ACK is expected, or the reverse, one cycle after the next head for that output. A refusal state that is not kept shows as an ACK on the body flit that follows a refused head. A round-robin pointer that lags shows in the second contested round, where the wrong input is granted. A queue count that is off shows as a NACK that arrives one flit early or late during a stalled fill, or as a flit missing or repeated when the output drains.

// File: rtl/gbn_pkg.sv
package gbn_pkg;
  typedef enum logic [1:0] {
    FK_IDLE = 2'd0,
    FK_HEAD = 2'd1,
    FK_BODY = 2'd2,
    FK_TAIL = 2'd3
  } flit_kind_e;
endpackage

// File: rtl/gbn_arb.sv
module gbn_arb #(
  parameter int N  = 4,
  parameter int RR = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;
  logic          any;
  int            base;

  always_comb begin
    grant = '0;
    any   = 1'b0;
    win   = '0;
    base  = (RR != 0) ? int'(ptr) : 0;
    for (int k = 0; k < N; k++) begin
      int t;
      t = (base + k) % N;
      if (!any && req[t]) begin
        grant[t] = 1'b1;
        any      = 1'b1;
        win      = PW'(t);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || RR == 0) ptr <= '0;
    else if (any) ptr <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
  end

  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  p_grant_has_req_r5: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);
endmodule

// File: rtl/gbn_outq.sv
module gbn_outq #(
  parameter int W     = 26,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          pop;

  assign full = (count == CW'(DEPTH));
  assign pop  = (count != '0) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop) begin
        rptr      <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        out_data  <= mem[rptr];
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      count <= count + CW'(wr_en) - CW'(pop);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/gbn_switch.sv
module gbn_switch
  import gbn_pkg::*;
#(
  parameter int NIN    = 4,
  parameter int NOUT   = 4,
  parameter int DW     = 16,
  parameter int RW     = 8,
  parameter int QDEPTH = 4,
  parameter int RR     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIN-1:0]    in_valid,
  input  logic [2*NIN-1:0]  in_kind,
  input  logic [RW*NIN-1:0] in_route,
  input  logic [DW*NIN-1:0] in_data,
  output logic [NIN-1:0]    in_ack,
  output logic [NIN-1:0]    in_nack,
  input  logic [NOUT-1:0]   out_ready,
  output logic [NOUT-1:0]   out_valid,
  output logic [2*NOUT-1:0] out_kind,
  output logic [RW*NOUT-1:0] out_route,
  output logic [DW*NOUT-1:0] out_data
);
  localparam int LW = (NOUT > 1) ? $clog2(NOUT) : 1;
  localparam int FW = 2 + RW + DW;

  logic [1:0]    kind  [NIN];
  logic [RW-1:0] route [NIN];
  logic [DW-1:0] data  [NIN];
  logic [LW-1:0] tgt   [NIN];
  logic [LW-1:0] dest  [NIN];
  logic [NIN-1:0] head_v, flow_v, tgt_ok, accept, drop;

  logic [NIN-1:0] path_vld, drop_st;
  logic [LW-1:0]  path_out [NIN];

  logic [NIN-1:0] holders [NOUT];
  logic [NIN-1:0] req     [NOUT];
  logic [NIN-1:0] gnt     [NOUT];
  logic [NOUT-1:0] avail, full, wr_en;
  logic [FW-1:0]  wr_data [NOUT];
  logic [FW-1:0]  q_out   [NOUT];

  for (genvar i = 0; i < NIN; i++) begin : g_in
    assign kind[i]   = in_kind[2*i +: 2];
    assign route[i]  = in_route[RW*i +: RW];
    assign data[i]   = in_data[DW*i +: DW];
    assign tgt[i]    = route[i][LW-1:0];
    assign tgt_ok[i] = (int'(tgt[i]) < NOUT);
    assign head_v[i] = in_valid[i] && (kind[i] == FK_HEAD);
    assign flow_v[i] = in_valid[i] && (kind[i] == FK_BODY || kind[i] == FK_TAIL);
    assign dest[i]   = head_v[i] ? tgt[i] : path_out[i];
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    always_comb begin
      for (int i = 0; i < NIN; i++) begin
        holders[o][i] = path_vld[i] && (path_out[i] == LW'(o));
        req[o][i]     = head_v[i] && tgt_ok[i] && (tgt[i] == LW'(o));
      end
    end
    assign avail[o] = (!(|holders[o]) || (|(holders[o] & head_v))) && !full[o];

    gbn_arb #(.N(NIN), .RR(RR)) u_arb (
      .clk   (clk),
      .rst   (rst),
      .req   (req[o] & {NIN{avail[o]}}),
      .grant (gnt[o])
    );

    always_comb begin
      wr_en[o]   = 1'b0;
      wr_data[o] = '0;
      for (int i = 0; i < NIN; i++) begin
        if (accept[i] && dest[i] == LW'(o)) begin
          wr_en[o]   = 1'b1;
          wr_data[o] = {kind[i], head_v[i] ? (route[i] >> LW) : route[i], data[i]};
        end
      end
    end

    gbn_outq #(.W(FW), .DEPTH(QDEPTH)) u_q (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en[o]),
      .wr_data   (wr_data[o]),
      .full      (full[o]),
      .out_ready (out_ready[o]),
      .out_valid (out_valid[o]),
      .out_data  (q_out[o])
    );

    assign out_kind[2*o +: 2]   = q_out[o][FW-1 -: 2];
    assign out_route[RW*o +: RW] = q_out[o][DW +: RW];
    assign out_data[DW*o +: DW]  = q_out[o][DW-1:0];

    p_one_holder_r6: assert property (@(posedge clk) disable iff (rst)
      $countones(holders[o]) <= 1);
  end

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      accept[i] = 1'b0;
      if (head_v[i]) accept[i] = tgt_ok[i] && gnt[tgt[i]][i];
      else if (flow_v[i])
        accept[i] = !drop_st[i] && path_vld[i] && !full[path_out[i]];
      drop[i] = (head_v[i] || flow_v[i]) && !accept[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      path_vld <= '0;
      drop_st  <= '0;
      in_ack   <= '0;
      in_nack  <= '0;
      for (int i = 0; i < NIN; i++) path_out[i] <= '0;
    end else begin
      in_ack  <= accept;
      in_nack <= drop;
      for (int i = 0; i < NIN; i++) begin
        if (head_v[i]) begin
          path_vld[i] <= accept[i];
          drop_st[i]  <= !accept[i];
          if (accept[i]) path_out[i] <= tgt[i];
        end else if (flow_v[i]) begin
          if (!accept[i]) begin
            drop_st[i]  <= 1'b1;
            path_vld[i] <= 1'b0;
          end else if (kind[i] == FK_TAIL) begin
            path_vld[i] <= 1'b0;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NIN; i++) begin : g_chk
    p_resp_needs_flit_r2: assert property (@(posedge clk) disable iff (rst)
      (in_ack[i] || in_nack[i]) |-> $past(in_valid[i]));
    p_drop_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      (drop_st[i] && flow_v[i]) |=> in_nack[i]);
  end
endmodule

// File: tb/sim_gbn_switch.sv
module sim_gbn_switch;
  localparam int NIN = 4, NOUT = 4, DW = 16, RW = 8, QD = 4;
  localparam logic [1:0] HD = 2'd1, BD = 2'd2, TL = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NIN-1:0]     in_valid;
  logic [2*NIN-1:0]   in_kind;
  logic [RW*NIN-1:0]  in_route;
  logic [DW*NIN-1:0]  in_data;
  logic [NOUT-1:0]    out_ready;
  logic [NIN-1:0]     a0, n0, a1, n1;
  logic [NOUT-1:0]    ov0, ov1;
  logic [2*NOUT-1:0]  ok0, ok1;
  logic [RW*NOUT-1:0] or0, or1;
  logic [DW*NOUT-1:0] od0, od1;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  gbn_switch #(.NIN(NIN), .NOUT(NOUT), .DW(DW), .RW(RW), .QDEPTH(QD), .RR(0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_route(in_route),
    .in_data(in_data), .in_ack(a0), .in_nack(n0), .out_ready(out_ready),
    .out_valid(ov0), .out_kind(ok0), .out_route(or0), .out_data(od0));

  gbn_switch #(.NIN(NIN), .NOUT(NOUT), .DW(DW), .RW(RW), .QDEPTH(QD), .RR(1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_route(in_route),
    .in_data(in_data), .in_ack(a1), .in_nack(n1), .out_ready(out_ready),
    .out_valid(ov1), .out_kind(ok1), .out_route(or1), .out_data(od1));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = '0; in_kind = '0; in_route = '0; in_data = '0;
  endtask

  task automatic put(int i, logic [1:0] k, logic [RW-1:0] r, logic [DW-1:0] d);
    in_valid[i] = 1'b1;
    in_kind[2*i +: 2]   = k;
    in_route[RW*i +: RW] = r;
    in_data[DW*i +: DW]  = d;
  endtask

  task automatic t_reset();
    check("R2 reset ack", 32'(a0 | n0), 0);
    check("R1 reset out_valid", 32'(ov0 | ov1), 0);
  endtask

  task automatic t_basic();
    idle(); put(1, HD, 8'hB6, 16'hA1A1); step();
    check("R2 head ack", 32'(a0[1]), 1);
    check("R2 head no nack", 32'(n0[1]), 0);
    check("R1 not early", 32'(ov0[2]), 0);
    idle(); step();
    check("R1 head out", 32'(ov0[2]), 1);
    check("R3 head kind", 32'(ok0[4 +: 2]), 32'(HD));
    check("R3 head route shifted", 32'(or0[16 +: 8]), 32'h2D);
    check("R1 head data", 32'(od0[32 +: 16]), 32'hA1A1);
    check("R2 idle no response", 32'(a0 | n0), 0);
    put(1, TL, 8'h55, 16'hA1A2); step();
    check("R2 tail ack", 32'(a0[1]), 1);
    idle(); step();
    check("R3 tail route kept", 32'(or0[16 +: 8]), 32'h55);
    check("R10 tail data", 32'(od0[32 +: 16]), 32'hA1A2);
    step();
    check("R1 output drained", 32'(ov0), 0);
  endtask

  task automatic t_arb();
    idle(); put(0, HD, 8'h01, 16'h1000); put(3, HD, 8'h01, 16'h3000); step();
    check("R4 fixed low wins", 32'({n0[3], a0[0]}), 32'h3);
    check("R5 rr start at 0", 32'({n1[3], a1[0]}), 32'h3);
    idle(); put(0, TL, 8'h00, 16'h1001); step();
    check("R6 tail ack", 32'({a1[0], a0[0]}), 32'h3);
    idle(); step();
    put(0, HD, 8'h01, 16'h1100); put(3, HD, 8'h01, 16'h3100); step();
    check("R4 fixed again low", 32'({n0[3], a0[0]}), 32'h3);
    check("R5 rr moved past 0", 32'({n1[0], a1[3]}), 32'h3);
    idle(); put(0, TL, 8'h00, 16'h1101); put(3, TL, 8'h00, 16'h3101); step();
    check("R8 u0 loser tail nack", 32'({n0[3], a0[0]}), 32'h3);
    check("R8 u1 loser tail nack", 32'({n1[0], a1[3]}), 32'h3);
    idle(); step(); step(); step();
  endtask

  task automatic t_hold();
    idle(); put(2, HD, 8'h03, 16'h2000); step();
    check("R6 owner head ack", 32'(a0[2]), 1);
    idle(); put(0, HD, 8'h03, 16'h0100); put(2, BD, 8'h00, 16'h2001); step();
    check("R6 held output nack", 32'(n0[0]), 1);
    check("R6 owner body ack", 32'(a0[2]), 1);
    idle(); put(2, TL, 8'h00, 16'h2002); step();
    check("R6 owner tail ack", 32'(a0[2]), 1);
    idle(); put(0, HD, 8'h03, 16'h0200); step();
    check("R9 resend head ack", 32'(a0[0]), 1);
    idle(); put(0, TL, 8'h00, 16'h0201); step();
    check("R6 new owner tail ack", 32'(a0[0]), 1);
    idle(); step(); step();
  endtask

  task automatic t_drop();
    idle(); put(3, HD, 8'h00, 16'h3A00); step();
    check("R6 holder ack", 32'(a0[3]), 1);
    idle(); put(1, HD, 8'h00, 16'h1A00); step();
    check("R6 refused head", 32'(n0[1]), 1);
    idle(); put(3, TL, 8'h00, 16'h3A01); step();
    check("R6 holder tail", 32'(a0[3]), 1);
    idle(); put(1, BD, 8'h00, 16'h1A01); step();
    check("R8 body after drop nack", 32'({a0[1], n0[1]}), 32'h1);
    idle(); step();
    check("R8 dropped body not forwarded", 32'(ov0[0]), 0);
    put(1, TL, 8'h00, 16'h1A02); step();
    check("R8 tail after drop nack", 32'(n0[1]), 1);
    idle(); put(1, HD, 8'h00, 16'h1B00); step();
    check("R9 head clears drop", 32'(a0[1]), 1);
    idle(); step();
    check("R9 head forwarded", 32'(od0[0 +: 16]), 32'h1B00);
    put(1, TL, 8'h00, 16'h1B01); step();
    check("R9 tail ack", 32'(a0[1]), 1);
    idle(); step(); step();
  endtask

  task automatic t_full();
    out_ready[2] = 1'b0;
    for (int k = 0; k < 6; k++) begin
      idle();
      put(0, (k == 0) ? HD : BD, (k == 0) ? 8'h02 : 8'h00, 16'(16'h5000 + k));
      step();
      if (k < 5) check("R7 accepted below full", 32'(a0[0]), 1);
      else       check("R7 nack when full", 32'({a0[0], n0[0]}), 32'h1);
      if (k >= 1) check("R10 stalled output holds", 32'({ov0[2], od0[32 +: 16]}), 32'h15000);
    end
    idle();
    out_ready[2] = 1'b1;
    for (int m = 0; m < 5; m++) begin
      check("R10 drain order", 32'({ov0[2], od0[32 +: 16]}), 32'(17'h10000 + 17'h5000 + m));
      step();
    end
    check("R7 refused flit absent", 32'(ov0[2]), 0);
  endtask

  initial begin
    #400000ns;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    out_ready = '1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_arb();
    t_hold();
    t_drop();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule